// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block walks a chain of command nodes held in a 2 MB word-addressed system memory. Each node is one header word followed by its payload words. The block forwards each node's payload, in order, to a downstream command consumer over a valid/ready word stream. The header packs an 8-bit payload length above a 24-bit pointer to the next node.

A walk begins with a start pulse and a start address. It ends when the current node address carries the end-of-list flag. It also ends when the node count reaches a guard limit, because a chain that points back into itself would otherwise never finish. At the end the block pulses `done`, shows the address where it stopped, and flags whether the guard was the reason.

Along the way the block adds up a cost figure for the walk. The memory arbiter and the consumer sit outside the block.

Top module: `dma_chain_walker`

## Requirements
- R1: A header word carries the payload count in bits 31:24 and the next-node byte address in bits 23:0. Exactly that many words, taken from the word addresses directly after the header, are forwarded in memory order.
- R2: A walk ends without reading memory once bit 23 of the current node address is 1. This includes a start address that already has bit 23 set.
- R3: The memory word address of a node is bits 20:2 of its byte address. Bits 22:21 have no effect on which word is read.
- R4: A node whose count is 0 forwards no word, and the walk continues at its next-node address.
- R5: Suppose LOOP_LIMIT headers have been read and the next address does not end the walk. The walk then stops without another read and sets `loop_err`. A chain of exactly LOOP_LIMIT nodes whose last pointer ends the walk finishes with `loop_err` at 0.
- R6: `walk_cost` is cleared at start and grows by 5 plus the payload count for each header read.
- R7: `progress_addr` takes the start address at start. After each node's last word is accepted (or after its header, for a zero-length node), it takes that node's next-node address. It then holds the stop address.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `progress_addr` hold, no memory request is made, and no word is lost.
- R9: `done` is a one-cycle pulse at the end of each walk. A start pulse during a walk is ignored.
- R10: After reset, `mem_req`, `out_valid`, `done`, `loop_err` are 0, and `progress_addr` and `walk_cost` are 0.
- R11: A memory request stays asserted with a stable address until `mem_req_ready` is 1. The read data arrives on `mem_rsp_valid` in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| start_addr | input | 24 | Byte address of the first node |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | SPACE_BITS-2 | Word address of the read |
| mem_req_ready | input | 1 | Request accepted this cycle |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| out_valid | output | 1 | Payload word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | 32 | Payload word |
| done | output | 1 | One-cycle end-of-walk pulse |
| loop_err | output | 1 | Walk stopped by the node-count guard |
| progress_addr | output | 24 | Address reached by the walk |
| walk_cost | output | COST_W | Accumulated cost of the walk |

## Verification
Several corner cases are exercised directly:
- A start address that is already an end marker. A design that fetches first would read a header it must not touch.
- Zero-length nodes, both mixed into a normal chain and forming a whole chain.
- A chain of exactly the guard limit next to one node longer. Testing the guard before the end flag would raise a false loop error on the first; an off-by-one count would miss the second.
- A self-pointing node, which has to stop with the error flag.
- An aliased start address with bits 22:21 set.

Consumer stalls and slow memory grants, both held and toggling, target designs that drop or repeat a word. A partial-progress check catches a `progress_addr` that updates at the header rather than after the payload.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    localparam int WORD_W        = 32;
    localparam int LEN_W         = 8;
    localparam int PTR_W         = 24;
    localparam int END_BIT       = 23;
    localparam int NODE_OVERHEAD = 5;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [PTR_W-1:0]  ptr_t;
    typedef logic [LEN_W-1:0]  len_t;

    typedef struct packed {
        len_t len;
        ptr_t next;
    } node_hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_PAY_REQ,
        ST_PAY_WAIT,
        ST_PAY_PUSH,
        ST_FINISH
    } walk_state_t;

    function automatic node_hdr_t unpack_hdr(input word_t w);
        return node_hdr_t'(w);
    endfunction

    function automatic logic is_end(input ptr_t a);
        return a[END_BIT];
    endfunction

endpackage

// File: rtl/dcw_node_guard.sv
module dcw_node_guard
    import dcw_pkg::*;
#(
    parameter int LOOP_LIMIT = 8192,
    parameter int COST_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              node_add,
    input  len_t              node_len,
    output logic              limit_hit,
    output logic [COST_W-1:0] cost
);
    localparam int CNT_W = $clog2(LOOP_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LOOP_LIMIT);

    logic [CNT_W-1:0] node_cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            node_cnt <= '0;
            cost     <= '0;
        end else if (node_add) begin
            node_cnt <= (node_cnt == LIMIT_V) ? node_cnt : node_cnt + 1'b1;
            cost     <= cost + COST_W'(NODE_OVERHEAD) + COST_W'(node_len);
        end
    end

    assign limit_hit = (node_cnt == LIMIT_V);

endmodule

// File: rtl/dcw_word_stage.sv
module dcw_word_stage
    import dcw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  word_t load_data,
    input  logic  out_ready,
    output logic  out_valid,
    output word_t out_data,
    output logic  taken
);
    assign taken = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (taken) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/dcw_walk_ctrl.sv
module dcw_walk_ctrl
    import dcw_pkg::*;
#(
    parameter int SPACE_BITS = 21,
    localparam int MEM_AW    = SPACE_BITS - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  ptr_t              start_addr,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  word_t             mem_rsp_data,
    input  logic              limit_hit,
    output logic              guard_clear,
    output logic              node_add,
    output len_t              node_len,
    output logic              word_load,
    input  logic              word_taken,
    output logic              done,
    output logic              loop_err,
    output ptr_t              cur_addr
);
    walk_state_t       state;
    logic [MEM_AW-1:0] rd_ptr;
    len_t              remain;
    ptr_t              next_addr;
    node_hdr_t         rsp_hdr;

    assign rsp_hdr = unpack_hdr(mem_rsp_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_addr  <= '0;
            rd_ptr    <= '0;
            remain    <= '0;
            next_addr <= '0;
            loop_err  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        cur_addr <= start_addr;
                        loop_err <= 1'b0;
                        state    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (is_end(cur_addr)) begin
                        state <= ST_FINISH;
                    end else if (limit_hit) begin
                        loop_err <= 1'b1;
                        state    <= ST_FINISH;
                    end else begin
                        rd_ptr <= cur_addr[SPACE_BITS-1:2];
                        state  <= ST_HDR_REQ;
                    end
                end
                ST_HDR_REQ: begin
                    if (mem_req_ready) state <= ST_HDR_WAIT;
                end
                ST_HDR_WAIT: begin
                    if (mem_rsp_valid) begin
                        next_addr <= rsp_hdr.next;
                        remain    <= rsp_hdr.len;
                        rd_ptr    <= rd_ptr + 1'b1;
                        if (rsp_hdr.len == '0) begin
                            cur_addr <= rsp_hdr.next;
                            state    <= ST_CHECK;
                        end else begin
                            state <= ST_PAY_REQ;
                        end
                    end
                end
                ST_PAY_REQ: begin
                    if (mem_req_ready) state <= ST_PAY_WAIT;
                end
                ST_PAY_WAIT: begin
                    if (mem_rsp_valid) state <= ST_PAY_PUSH;
                end
                ST_PAY_PUSH: begin
                    if (word_taken) begin
                        rd_ptr <= rd_ptr + 1'b1;
                        remain <= remain - 1'b1;
                        if (remain == LEN_W'(1)) begin
                            cur_addr <= next_addr;
                            state    <= ST_CHECK;
                        end else begin
                            state <= ST_PAY_REQ;
                        end
                    end
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req     = (state == ST_HDR_REQ) || (state == ST_PAY_REQ);
        mem_addr    = rd_ptr;
        guard_clear = (state == ST_IDLE) && start;
        node_add    = (state == ST_HDR_WAIT) && mem_rsp_valid;
        node_len    = rsp_hdr.len;
        word_load   = (state == ST_PAY_WAIT) && mem_rsp_valid;
        done        = (state == ST_FINISH);
    end

endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
    import dcw_pkg::*;
#(
    parameter int SPACE_BITS = 21,
    parameter int LOOP_LIMIT = 8192,
    parameter int COST_W     = 32,
    localparam int MEM_AW    = SPACE_BITS - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [23:0]       start_addr,
    output logic              mem_req,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              done,
    output logic              loop_err,
    output logic [23:0]       progress_addr,
    output logic [COST_W-1:0] walk_cost
);
    logic limit_hit;
    logic guard_clear;
    logic node_add;
    len_t node_len;
    logic word_load;
    logic word_taken;

    dcw_walk_ctrl #(.SPACE_BITS(SPACE_BITS)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .start_addr   (start_addr),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data (mem_rsp_data),
        .limit_hit    (limit_hit),
        .guard_clear  (guard_clear),
        .node_add     (node_add),
        .node_len     (node_len),
        .word_load    (word_load),
        .word_taken   (word_taken),
        .done         (done),
        .loop_err     (loop_err),
        .cur_addr     (progress_addr)
    );

    dcw_node_guard #(.LOOP_LIMIT(LOOP_LIMIT), .COST_W(COST_W)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .clear    (guard_clear),
        .node_add (node_add),
        .node_len (node_len),
        .limit_hit(limit_hit),
        .cost     (walk_cost)
    );

    dcw_word_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .load     (word_load),
        .load_data(mem_rsp_data),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_data (out_data),
        .taken    (word_taken)
    );

endmodule

// File: rtl/dma_chain_walker_checker.sv
module dma_chain_walker_checker #(
    parameter int MEM_AW = 19
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic [MEM_AW-1:0] mem_addr,
    input logic              mem_req_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [31:0]       out_data,
    input logic              done,
    input logic              loop_err,
    input logic [23:0]       progress_addr
);
    assert_hold_word_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    assert_no_read_while_full_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !mem_req);

    assert_progress_still_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> $stable(progress_addr));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_req_ready |=> mem_req && $stable(mem_addr));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_err_at_done_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(loop_err) |-> done);

    assert_end_marker_R2: assert property (@(posedge clk) disable iff (rst)
        done && !loop_err |-> progress_addr[23]);

endmodule

bind dma_chain_walker dma_chain_walker_checker #(.MEM_AW(SPACE_BITS - 2)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_req_ready(mem_req_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .done         (done),
    .loop_err     (loop_err),
    .progress_addr(progress_addr)
);

// File: tb/dma_chain_walker_test.sv
`timescale 1ns/1ps
module dma_chain_walker_test;

    localparam int LIMIT = 6;
    localparam int NV    = 7;

    localparam logic [23:0] V_START [NV] = '{24'h000040, 24'h000040, 24'h800000, 24'h000100,
                                             24'h600040, 24'h000140, 24'h00013C};
    localparam int          V_WORDS [NV] = '{5, 5, 0, 6, 5, 0, 0};
    localparam logic [23:0] V_PROG  [NV] = '{24'h800123, 24'h800123, 24'h800000, 24'h000100,
                                             24'h800123, 24'h800000, 24'h000154};
    localparam logic        V_ERR   [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam int          V_COST  [NV] = '{20, 20, 0, 36, 20, 30, 30};
    localparam logic        V_RTOG  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic        V_GSLOW [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam string       V_TAG   [NV] = '{"R1 chain", "R8 R11 stalls", "R2 start-at-end",
                                             "R5 self-loop", "R3 alias", "R4 zero-len at limit",
                                             "R5 one past limit"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic        mem_req;
    logic [18:0] mem_addr;
    logic        mem_req_ready;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_data;
    logic        done;
    logic        loop_err;
    logic [23:0] progress_addr;
    logic [31:0] walk_cost;

    logic [31:0] mem [256];
    logic [31:0] exp_q [$];
    logic        gnt_slow = 1'b0;
    logic        rdy_tog  = 1'b0;
    logic        rdy_man  = 1'b1;
    int          checks = 0;
    int          fails  = 0;
    int          got_words = 0;
    int          done_cnt  = 0;
    int          cyc = 0;

    always #2 clk = ~clk;

    dma_chain_walker #(.LOOP_LIMIT(LIMIT)) uut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done), .loop_err(loop_err), .progress_addr(progress_addr),
        .walk_cost(walk_cost)
    );

    always @(posedge clk) begin
        if (rst) begin
            mem_req_ready <= 1'b1;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            out_ready     <= 1'b1;
        end else begin
            mem_req_ready <= gnt_slow ? ~mem_req_ready : 1'b1;
            mem_rsp_valid <= mem_req && mem_req_ready;
            mem_rsp_data  <= mem[mem_addr[7:0]];
            out_ready     <= rdy_tog ? ~out_ready : rdy_man;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid && out_ready) begin
                got_words++;
                if (exp_q.size() == 0) chk(1'b0, "R1 unexpected word", out_data, 32'h0);
                else chk(out_data == exp_q[0], "R1 word order", out_data, exp_q[0]);
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
            if (done) done_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Reference walk over the bench memory, from the header format alone
    task automatic ref_walk(input logic [23:0] s);
        logic [23:0] a;
        a = s;
        exp_q.delete();
        for (int n = 0; n < LIMIT && !a[23]; n++) begin
            logic [31:0] h;
            h = mem[a[9:2]];
            for (int k = 0; k < int'(h[31:24]); k++)
                exp_q.push_back(mem[8'(a[9:2] + 8'(k + 1))]);
            a = h[23:0];
        end
    endtask

    task automatic pulse_start(input logic [23:0] s);
        @(posedge clk); #1 start_addr = s; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (done) break;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic put_node(input int idx, input int len, input logic [23:0] nxt);
        mem[idx] = {8'(len), nxt};
        for (int k = 1; k <= len; k++) mem[idx + k] = 32'hE5A0_0000 + 32'(idx * 16 + k);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        put_node(8'h10, 2, 24'h000080);
        put_node(8'h20, 0, 24'h0000C0);
        put_node(8'h30, 3, 24'h800123);
        put_node(8'h40, 1, 24'h000100);
        put_node(8'h4F, 0, 24'h000140);
        for (int k = 8'h50; k < 8'h55; k++) put_node(k, 0, 24'((k + 1) * 4));
        put_node(8'h55, 0, 24'h800000);

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!mem_req && !out_valid && !done && !loop_err, "R10 idle outputs",
            {mem_req, out_valid, done, loop_err}, 32'h0);
        chk(progress_addr == 24'h0 && walk_cost == 32'h0, "R10 progress/cost", progress_addr, 32'h0);

        for (int v = 0; v < NV; v++) begin
            gnt_slow = V_GSLOW[v];
            rdy_tog  = V_RTOG[v];
            rdy_man  = 1'b1;
            ref_walk(V_START[v]);
            got_words = 0;
            done_cnt  = 0;
            pulse_start(V_START[v]);
            wait_done();
            chk(got_words == V_WORDS[v], {V_TAG[v], " R1 word count"}, got_words, V_WORDS[v]);
            chk(progress_addr == V_PROG[v], {V_TAG[v], " R7 stop address"}, progress_addr, V_PROG[v]);
            chk(loop_err == V_ERR[v], {V_TAG[v], " R5 error flag"}, loop_err, V_ERR[v]);
            chk(walk_cost == 32'(V_COST[v]), {V_TAG[v], " R6 cost"}, walk_cost, V_COST[v]);
            chk(done_cnt == 1, {V_TAG[v], " R9 done pulse"}, done_cnt, 1);
        end
        gnt_slow = 1'b0;
        rdy_tog  = 1'b0;

        // R7/R8: consumer stall, partial progress
        ref_walk(24'h000040);
        got_words = 0;
        rdy_man = 1'b0;
        repeat (2) @(posedge clk);
        pulse_start(24'h000040);
        repeat (20) @(negedge clk);
        chk(progress_addr == 24'h000040, "R7 progress before first node done", progress_addr, 24'h40);
        chk(out_valid && out_data == mem[8'h11], "R8 word held under stall", out_data, mem[8'h11]);
        chk(!mem_req, "R8 no read while stalled", mem_req, 0);
        #1 rdy_man = 1'b1;
        wait (got_words == 2);
        @(posedge clk); #1 rdy_man = 1'b0;
        repeat (20) @(negedge clk);
        chk(progress_addr == 24'h0000C0, "R7 progress after two nodes", progress_addr, 24'hC0);
        chk(out_valid && out_data == mem[8'h31], "R8 third word pending", out_data, mem[8'h31]);
        #1 rdy_man = 1'b1;
        wait_done();
        chk(got_words == 5, "R8 no word lost", got_words, 5);

        // R9: start during a walk is ignored
        ref_walk(24'h000040);
        got_words = 0;
        done_cnt  = 0;
        pulse_start(24'h000040);
        repeat (3) @(posedge clk);
        #1 start_addr = 24'h000100; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        wait_done();
        chk(got_words == 5 && progress_addr == 24'h800123, "R9 restart ignored", progress_addr, 24'h800123);
        chk(done_cnt == 1 && !loop_err, "R9 single done", done_cnt, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule